// File: doc/BRIEF.md
# Multi-processor address frame filter

This block sits between a 9-bit serial receiver and its receive buffer and implements addressed multi-drop reception. Each completed frame arrives as a one-cycle pulse with its nine bits. When the multi-processor mode is on, the top bit is compared with a programmable polarity. A frame whose top bit matches is an address frame. Any other frame is a data frame.

Address frames always go to the buffer and raise a sticky interrupt flag, even on a node that has blocked its receiver. This lets every node see each address. Data frames go to the buffer only while the node is unblocked. Software looks at each address. It unblocks the receiver when it is the addressed node, and blocks it again when the transfer is over.

Frames that would be loaded while the buffer is full are dropped, and a sticky overflow flag is raised. Both flags are cleared by write-one-to-clear pulses.

Top module: `mp_addr_filter`

## Requirements
- R1: After reset, `wr_en_o`, `addr_flag_o`, `ovf_flag_o` and `blocked_o` are all 0.
- R2: While `rx_en_i` is 0, a frame pulse writes nothing, sets no flag and sets no overflow.
- R3: While `mp_en_i` is 0, every frame is a data frame and never sets `addr_flag_o`.
- R4: While `mp_en_i` is 1, a frame is an address frame exactly when bit 8 of `frame_i` equals `addr_bit_i`. This holds for both values of `addr_bit_i`.
- R5: With the receiver on, an address frame is written to the buffer when the buffer is not full, whether or not the node is blocked.
- R6: With the receiver on, a data frame is written only if `blocked_o` was 0 in the cycle of the frame pulse. Otherwise it is dropped.
- R7: `block_i` sets and `unblock_i` clears `blocked_o` on the next cycle. When both are high, block wins. A command in the same cycle as a frame pulse does not affect that frame.
- R8: An address frame sets `addr_flag_o` on the next cycle. The flag holds until an `addr_flag_clr_i` pulse. A set and a clear in the same cycle leave the flag set.
- R9: A frame that would be written while `buf_full_i` is 1 is dropped and sets `ovf_flag_o` on the next cycle. An address frame still sets `addr_flag_o`. The overflow flag holds until an `ovf_clr_i` pulse, and set wins over clear.
- R10: An accepted frame asserts `wr_en_o` for one cycle, the cycle after the frame pulse. In that cycle `wr_data_o` carries the nine frame bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| mp_en_i | input | 1 | Multi-processor mode enable |
| addr_bit_i | input | 1 | Top-bit value that marks an address frame |
| frame_vld_i | input | 1 | Pulse at stop-bit completion of a frame |
| frame_i | input | DATA_W+1 | Received frame, top bit is the address/data marker |
| buf_full_i | input | 1 | Receive buffer has no free entry |
| block_i | input | 1 | Block command pulse |
| unblock_i | input | 1 | Unblock command pulse |
| addr_flag_clr_i | input | 1 | Clear pulse for the address flag |
| ovf_clr_i | input | 1 | Clear pulse for the overflow flag |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_data_o | output | DATA_W+1 | Buffer write data |
| addr_flag_o | output | 1 | Sticky address-frame interrupt flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| blocked_o | output | 1 | Current receiver block state |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that command, clear and frame inputs are sampled only at that edge, so a level held for several cycles counts as one event per cycle.

The bench changes every input on the falling edge and holds it through the next rising edge. Block, unblock and clear commands are drawn with low probability. Frame pulses, buffer-full and the two enables are drawn independently, so the blocked, full and mode-off cases, and commands that coincide with a frame, all occur within the run.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  typedef enum logic [1:0] {
    FR_NONE = 2'd0,
    FR_DATA = 2'd1,
    FR_ADDR = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/mpf_classify.sv
module mpf_classify (
  input  logic                  vld_i,
  input  logic                  rx_en_i,
  input  logic                  mp_en_i,
  input  logic                  addr_bit_i,
  input  logic                  marker_i,
  output mpf_pkg::frame_kind_e  kind_o
);
  import mpf_pkg::*;

  always_comb begin
    kind_o = FR_NONE;
    if (vld_i && rx_en_i) begin
      if (mp_en_i && (marker_i == addr_bit_i)) kind_o = FR_ADDR;
      else                                     kind_o = FR_DATA;
    end
  end
endmodule

// File: rtl/mpf_block_ctl.sv
module mpf_block_ctl #(
  parameter bit RST_BLOCKED = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic block_i,
  input  logic unblock_i,
  output logic blocked_o
);
  logic blocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        blocked_q <= RST_BLOCKED;
    else if (block_i)   blocked_q <= 1'b1;  // block wins
    else if (unblock_i) blocked_q <= 1'b0;
  end

  assign blocked_o = blocked_q;
endmodule

// File: rtl/mpf_sticky_flag.sv
module mpf_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set wins over clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter #(
  parameter int unsigned DATA_W      = 8,
  parameter bit          RST_BLOCKED = 1'b0,
  localparam int unsigned FRAME_W    = DATA_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_en_i,
  input  logic               mp_en_i,
  input  logic               addr_bit_i,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               buf_full_i,
  input  logic               block_i,
  input  logic               unblock_i,
  input  logic               addr_flag_clr_i,
  input  logic               ovf_clr_i,
  output logic               wr_en_o,
  output logic [FRAME_W-1:0] wr_data_o,
  output logic               addr_flag_o,
  output logic               ovf_flag_o,
  output logic               blocked_o
);
  import mpf_pkg::*;

  frame_kind_e       kind;
  logic              blocked;
  logic              load_req;
  logic              accept;
  logic              ovf_set;
  logic              wr_en_q;
  logic [FRAME_W-1:0] wr_data_q;

  mpf_classify u_classify (
    .vld_i      (frame_vld_i),
    .rx_en_i    (rx_en_i),
    .mp_en_i    (mp_en_i),
    .addr_bit_i (addr_bit_i),
    .marker_i   (frame_i[FRAME_W-1]),
    .kind_o     (kind)
  );

  mpf_block_ctl #(.RST_BLOCKED(RST_BLOCKED)) u_block (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .block_i   (block_i),
    .unblock_i (unblock_i),
    .blocked_o (blocked)
  );

  // block state as registered before this cycle's commands
  assign load_req = (kind == FR_ADDR) || ((kind == FR_DATA) && !blocked);
  assign accept   = load_req && !buf_full_i;
  assign ovf_set  = load_req &&  buf_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= accept;
      if (accept) wr_data_q <= frame_i;
    end
  end

  mpf_sticky_flag u_addr_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (kind == FR_ADDR),
    .clr_i  (addr_flag_clr_i),
    .flag_o (addr_flag_o)
  );

  mpf_sticky_flag u_ovf_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_set),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_flag_o)
  );

  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_data_q;
  assign blocked_o = blocked;
endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned FRAME_W = DATA_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rx_en_i,
  input logic               mp_en_i,
  input logic               addr_bit_i,
  input logic               frame_vld_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic               buf_full_i,
  input logic               block_i,
  input logic               unblock_i,
  input logic               addr_flag_clr_i,
  input logic               ovf_clr_i,
  input logic               wr_en_o,
  input logic [FRAME_W-1:0] wr_data_o,
  input logic               addr_flag_o,
  input logic               ovf_flag_o,
  input logic               blocked_o
);
  logic is_addr;
  assign is_addr = frame_vld_i && rx_en_i && mp_en_i && (frame_i[FRAME_W-1] == addr_bit_i);

  // R2
  rx_off_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && !rx_en_i) |=> !wr_en_o);

  // R3
  mp_off_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mp_en_i && addr_flag_clr_i) |=> !addr_flag_o);

  // R5
  addr_loaded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_addr && !buf_full_i) |=> wr_en_o);

  // R6
  blocked_data_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && blocked_o && !is_addr) |=> !wr_en_o);

  // R7
  block_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |=> blocked_o);

  // R7
  unblock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unblock_i && !block_i) |=> !blocked_o);

  // R8
  addr_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_addr |=> addr_flag_o);

  // R8
  addr_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_flag_o && !addr_flag_clr_i) |=> addr_flag_o);

  // R9
  full_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_i |=> !wr_en_o);

  // R9
  full_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_addr && buf_full_i) |=> (ovf_flag_o && addr_flag_o));

  // R10
  wr_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(frame_vld_i && rx_en_i && !buf_full_i));

  // R10
  wr_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && rx_en_i && !buf_full_i && !blocked_o) |=> (wr_en_o && wr_data_o == $past(frame_i)));
endmodule

bind mp_addr_filter mpf_checker #(.DATA_W(DATA_W)) u_mpf_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rx_en_i         (rx_en_i),
  .mp_en_i         (mp_en_i),
  .addr_bit_i      (addr_bit_i),
  .frame_vld_i     (frame_vld_i),
  .frame_i         (frame_i),
  .buf_full_i      (buf_full_i),
  .block_i         (block_i),
  .unblock_i       (unblock_i),
  .addr_flag_clr_i (addr_flag_clr_i),
  .ovf_clr_i       (ovf_clr_i),
  .wr_en_o         (wr_en_o),
  .wr_data_o       (wr_data_o),
  .addr_flag_o     (addr_flag_o),
  .ovf_flag_o      (ovf_flag_o),
  .blocked_o       (blocked_o)
);

// File: tb/tb_mp_addr_filter.sv
module tb_mp_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 9;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_en_i = 0, mp_en_i = 0, addr_bit_i = 0, frame_vld_i = 0;
  logic [FW-1:0] frame_i = '0;
  logic buf_full_i = 0, block_i = 0, unblock_i = 0, addr_flag_clr_i = 0, ovf_clr_i = 0;
  logic wr_en_o, addr_flag_o, ovf_flag_o, blocked_o;
  logic [FW-1:0] wr_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic e_wr = 0, e_aflag = 0, e_ovf = 0, e_blk = 0;
  logic [FW-1:0] e_data = '0;
  string wr_tag = "R1", af_tag = "R1", ovf_tag = "R1";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mp_addr_filter dut (.*);

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic is_addr_f(input logic rxe, input logic mpe, input logic ab, input logic [FW-1:0] d);
    return rxe && mpe && (d[FW-1] == ab);
  endfunction

  // drive at negedge, advance one clock, check at following negedge
  task automatic step(input logic fv, input logic rxe, input logic mpe, input logic ab,
                      input logic [FW-1:0] d, input logic full, input logic blk,
                      input logic ublk, input logic aclr, input logic oclr);
    logic addr, dat, load;
    frame_vld_i = fv; rx_en_i = rxe; mp_en_i = mpe; addr_bit_i = ab; frame_i = d;
    buf_full_i = full; block_i = blk; unblock_i = ublk;
    addr_flag_clr_i = aclr; ovf_clr_i = oclr;
    addr = fv && is_addr_f(rxe, mpe, ab, d);
    dat  = fv && rxe && !addr;
    load = addr || (dat && !e_blk);
    if (!fv)                    wr_tag = "R10";
    else if (!rxe)              wr_tag = "R2";
    else if (full)              wr_tag = "R9";
    else if (addr)              wr_tag = "R5";
    else if (dat && e_blk)      wr_tag = "R6";
    else if (!mpe)              wr_tag = "R3";
    else                        wr_tag = "R10";
    af_tag  = addr ? "R4" : (!mpe ? "R3" : "R8");
    ovf_tag = "R9";
    e_wr = load && !full;
    if (e_wr) e_data = d;
    if (addr) e_aflag = 1'b1; else if (aclr) e_aflag = 1'b0;
    if (load && full) e_ovf = 1'b1; else if (oclr) e_ovf = 1'b0;
    if (blk) e_blk = 1'b1; else if (ublk) e_blk = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(wr_en_o, e_wr, wr_tag, "wr_en");
    if (e_wr) begin
      checks++;
      if (wr_data_o !== e_data) begin
        errors++;
        $display("FAIL R10 wr_data: actual=%h expected=%h at %0t", wr_data_o, e_data, $time);
      end
    end
    chk(addr_flag_o, e_aflag, af_tag, "addr_flag");
    chk(ovf_flag_o, e_ovf, ovf_tag, "ovf_flag");
    chk(blocked_o, e_blk, "R7", "blocked");
  endtask

  initial begin
    repeat (1000000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(wr_en_o, 1'b0, "R1", "wr_en");
    chk(addr_flag_o, 1'b0, "R1", "addr_flag");
    chk(ovf_flag_o, 1'b0, "R1", "ovf_flag");
    chk(blocked_o, 1'b0, "R1", "blocked");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 receiver off: address-looking frame ignored
    step(1, 0, 1, 1, 9'h1A5, 0, 0, 0, 0, 0);
    // R3 mode off: marker bit ignored, frame loaded as data
    step(1, 1, 0, 1, 9'h155, 0, 0, 0, 0, 0);
    // R7 block and unblock together: block wins
    step(0, 1, 1, 1, 9'h000, 0, 1, 1, 0, 0);
    // R6 blocked data dropped
    step(1, 1, 1, 1, 9'h033, 0, 0, 0, 0, 0);
    // R5 / R4 blocked address frame loaded, polarity 1
    step(1, 1, 1, 1, 9'h142, 0, 0, 0, 0, 0);
    // R8 set and clear together keep flag
    step(1, 1, 1, 1, 9'h143, 0, 0, 0, 1, 0);
    step(0, 1, 1, 1, 9'h000, 0, 0, 0, 1, 0);
    // R7 unblock in frame cycle does not admit that frame
    step(1, 1, 1, 1, 9'h011, 0, 0, 1, 0, 0);
    // R7 frame after earlier unblock admitted
    step(1, 1, 1, 1, 9'h012, 0, 0, 0, 0, 0);
    // R4 polarity 0: top bit clear is address
    step(1, 1, 1, 0, 9'h07E, 0, 1, 0, 0, 0);
    step(1, 1, 1, 0, 9'h17E, 0, 0, 0, 1, 0);
    // R9 full with address frame: dropped, ovf and flag set
    step(1, 1, 1, 1, 9'h1FF, 1, 0, 0, 0, 0);
    step(0, 1, 1, 1, 9'h000, 0, 0, 0, 1, 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic fv, rxe, mpe, ab, full, blk, ublk, aclr, oclr;
      logic [FW-1:0] d;
      fv   = ($urandom % 3) == 0;
      rxe  = ($urandom % 8) != 0;
      mpe  = ($urandom % 4) != 0;
      ab   = ($urandom % 4) != 0;
      full = ($urandom % 6) == 0;
      blk  = ($urandom % 10) == 0;
      ublk = ($urandom % 8) == 0;
      aclr = ($urandom % 6) == 0;
      oclr = ($urandom % 6) == 0;
      d    = FW'($urandom);
      step(fv, rxe, mpe, ab, d, full, blk, ublk, aclr, oclr);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule